// File: doc/BRIEF.md
# Programmable Timer with Clear-on-Match and Single-Slope PWM Waveforms

This block is a 16-bit up-counter with a clock divider, two compare channels and a register that can set the count ceiling. Software programs it through a single write port. One control word selects the counting mode, the action of each output pin on a compare match, and the divider ratio. Three data words hold compare value A, compare value B and a ceiling/capture value. A fifth address clears the event flags.

Two families of waveform modes are provided. In clear-on-match mode the counter restarts after it reaches a ceiling taken from compare A or from the ceiling register. Writes to that ceiling act at once. In single-slope PWM mode the counter climbs from zero to a fixed or programmable ceiling and then restarts. In this mode the compare values pass through a holding stage and reach the comparators only at the ceiling, so a period is never cut short. Any other mode code lets the counter run freely over the full 16-bit range.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset the count, both waveform pins and all four flags read 0.
- R2: Control bits [10:8] select the divider. Codes 1, 2, 3, 4 and 5 advance the count once every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 hold the count still. A write to the control word restarts the divider phase.
- R3: Control bits [3:0] select the mode. Mode 4 uses compare A (address 1) as the ceiling, and mode 12 uses the ceiling register (address 3). In both, the count steps by one per tick and returns to 0 on the tick after it equals the ceiling. With pin action 1 (control bits [5:4] for pin A, [7:6] for pin B), a pin toggles each time the count matches its compare value, so a pin whose compare value equals the ceiling C toggles every N*(C+1) clocks.
- R4: In modes 4 and 12 a ceiling write acts on the next clock. If the new ceiling is below the count, the count runs on to 0xFFFF and wraps to 0 before any match occurs.
- R5: PWM modes 5, 6 and 7 use fixed ceilings of 0x00FF, 0x01FF and 0x03FF. Mode 14 uses the ceiling register and mode 15 uses compare A. The count runs from 0 to the ceiling and restarts.
- R6: In PWM modes, pin action 2 sets the pin at the ceiling-to-zero tick and clears it on a match. Pin action 3 does the reverse. The ceiling action wins when both apply at once. With ceiling C and compare value M ≤ C, the pin is high for M+1 of every C+1 ticks under action 2, and for C−M ticks under action 3.
- R7: In PWM modes a write to compare A or B is held and reaches the comparator only on the tick at which the count equals the ceiling. This applies also when compare A is the ceiling (mode 15).
- R8: Flag bit 0 (overflow) sets on a tick at count 0xFFFF in non-PWM modes, and on a tick at the ceiling in PWM modes. Bits 1 and 2 set on a tick where the count equals compare A or B. Bit 3 sets on a tick at the ceiling only in modes 12 and 14.
- R9: Flags stay set until a write to address 4 with a 1 in the flag's bit position. Bits written 0 leave their flags unchanged. A set event in the same cycle wins over the clear.
- R10: Pin action 0 drives the pin low from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1 compare A, 2 compare B, 3 ceiling, 4 flag clear |
| wr_data | input | 16 | Write data |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| flag_ovf | output | 1 | Overflow / ceiling-reached flag |
| flag_cmpa | output | 1 | Compare A match flag |
| flag_cmpb | output | 1 | Compare B match flag |
| flag_capt | output | 1 | Ceiling-register match flag |
| count | output | 16 | Current count |

## Verification
The hardest state to reach is the missed match: the ceiling must drop below a count that is already running. The bench lets the count climb to 500 against a ceiling of 999 and then writes 100. It follows the count through the full 16-bit range and checks that the overflow flag is set and the compare flag is clear when the count returns to zero. The held-compare timing needs a similar write in the middle of a period. In mode 15 the bench changes compare A while the count sits at 5, then measures the length of the current period and of the next one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_act_e;

  localparam logic [3:0] MODE_CTC_A   = 4'd4;
  localparam logic [3:0] MODE_CTC_CAP = 4'd12;
  localparam logic [3:0] MODE_PWM_8   = 4'd5;
  localparam logic [3:0] MODE_PWM_9   = 4'd6;
  localparam logic [3:0] MODE_PWM_10  = 4'd7;
  localparam logic [3:0] MODE_PWM_CAP = 4'd14;
  localparam logic [3:0] MODE_PWM_A   = 4'd15;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_CMPA  = 3'd1;
  localparam logic [2:0] ADR_CMPB  = 3'd2;
  localparam logic [2:0] ADR_CEIL  = 3'd3;
  localparam logic [2:0] ADR_FLAGS = 3'd4;

  function automatic logic mode_is_pwm(input logic [3:0] m);
    return (m == MODE_PWM_8) || (m == MODE_PWM_9) || (m == MODE_PWM_10) ||
           (m == MODE_PWM_CAP) || (m == MODE_PWM_A);
  endfunction

  function automatic logic mode_uses_ceil(input logic [3:0] m);
    return (m == MODE_CTC_CAP) || (m == MODE_PWM_CAP);
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] mask;
  logic             run;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    case (sel)
      3'd1: mask = '0;
      3'd2: mask = PSC_W'(7);
      3'd3: mask = PSC_W'(63);
      3'd4: mask = PSC_W'(255);
      3'd5: mask = PSC_W'(1023);
      default: begin
        run  = 1'b0;
        mask = '1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) div_q <= '0;
    else                div_q <= div_q + PSC_W'(1);
  end

  assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         at_top
);
  assign at_top = (cnt == top);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= at_top ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/tmr_cmp_reg.sv
module tmr_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         load,
  output logic [W-1:0] act
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act    <= '0;
    end else begin
      if (wr) hold_q <= wdata;
      if (wr && !buffered)      act <= wdata;
      else if (buffered && load) act <= hold_q;
    end
  end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     pwm,
  input  pin_act_e act,
  input  logic     match,
  input  logic     at_top,
  output logic     wave
);
  always_ff @(posedge clk) begin
    if (rst || act == PIN_OFF) begin
      wave <= 1'b0;
    end else if (tick) begin
      case (act)
        PIN_TOGGLE: if (match) wave <= ~wave;
        PIN_CLEAR: begin
          if (pwm && at_top) wave <= 1'b1;
          else if (match)    wave <= 1'b0;
        end
        PIN_SET: begin
          if (pwm && at_top) wave <= 1'b0;
          else if (match)    wave <= 1'b1;
        end
        default: wave <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import tmr_pkg::*;
#(
  parameter int W     = 16,
  parameter int PSC_W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         wave_a,
  output logic         wave_b,
  output logic         flag_ovf,
  output logic         flag_cmpa,
  output logic         flag_cmpb,
  output logic         flag_capt,
  output logic [W-1:0] count
);
  localparam int NCH   = 2;
  localparam int NFLAG = 4;

  logic [3:0]        mode_q;
  logic [1:0]        com_q [NCH];
  logic [2:0]        sel_q;
  logic [W-1:0]      ceil_q;
  logic              ctrl_wr;
  logic              pwm;
  logic              use_ceil;
  logic              tick;
  logic [W-1:0]      top_val;
  logic [W-1:0]      cnt_q;
  logic              at_top;
  logic [W-1:0]      cmp_act [NCH];
  logic [NCH-1:0]    match;
  logic [NCH-1:0]    wave_q;
  logic [NFLAG-1:0]  flag_q;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_clr;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      sel_q  <= '0;
      ceil_q <= '0;
      for (int c = 0; c < NCH; c++) com_q[c] <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q   <= wr_data[3:0];
        com_q[0] <= wr_data[5:4];
        com_q[1] <= wr_data[7:6];
        sel_q    <= wr_data[10:8];
      end
      if (wr_en && wr_addr == ADR_CEIL) ceil_q <= wr_data;
    end
  end

  assign pwm      = mode_is_pwm(mode_q);
  assign use_ceil = mode_uses_ceil(mode_q);

  always_comb begin
    case (mode_q)
      MODE_CTC_A, MODE_PWM_A:     top_val = cmp_act[0];
      MODE_CTC_CAP, MODE_PWM_CAP: top_val = ceil_q;
      MODE_PWM_8:                 top_val = W'(16'h00FF);
      MODE_PWM_9:                 top_val = W'(16'h01FF);
      MODE_PWM_10:                top_val = W'(16'h03FF);
      default:                    top_val = '1;
    endcase
  end

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .restart (ctrl_wr),
    .sel     (sel_q),
    .tick    (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .top    (top_val),
    .cnt    (cnt_q),
    .at_top (at_top)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    tmr_cmp_reg #(.W(W)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_en && (wr_addr == 3'(ch + 1))),
      .wdata    (wr_data),
      .buffered (pwm),
      .load     (tick && at_top),
      .act      (cmp_act[ch])
    );

    assign match[ch] = (cnt_q == cmp_act[ch]);

    tmr_wave u_wave (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .pwm    (pwm),
      .act    (pin_act_e'(com_q[ch])),
      .match  (match[ch]),
      .at_top (at_top),
      .wave   (wave_q[ch])
    );
  end

  assign flag_clr    = (wr_en && wr_addr == ADR_FLAGS) ? wr_data[NFLAG-1:0] : '0;
  assign flag_set[0] = tick && (pwm ? at_top : (cnt_q == '1));
  assign flag_set[1] = tick && match[0];
  assign flag_set[2] = tick && match[1];
  assign flag_set[3] = tick && use_ceil && at_top;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign wave_a    = wave_q[0];
  assign wave_b    = wave_q[1];
  assign flag_ovf  = flag_q[0];
  assign flag_cmpa = flag_q[1];
  assign flag_cmpb = flag_q[2];
  assign flag_capt = flag_q[3];
  assign count     = cnt_q;
endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top,
  input logic         pwm,
  input logic [3:0]   flags,
  input logic [3:0]   clr,
  input logic         wave_a,
  input logic [1:0]   com_a,
  input logic [2:0]   sel
);
  p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0) |=> $stable(cnt));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == top) |=> (cnt == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != top) |=> (cnt == $past(cnt) + W'(1)));

  p_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !pwm && cnt == '1) |=> flags[0]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == 4'd0));

  p_pin_off_r10: assert property (@(posedge clk) disable iff (rst)
    (com_a == 2'd0) |=> !wave_a);
endmodule

bind tmr_wavegen tmr_wavegen_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .cnt    (cnt_q),
  .top    (top_val),
  .pwm    (pwm),
  .flags  (flag_q),
  .clr    (flag_clr),
  .wave_a (wave_a),
  .com_a  (com_q[0]),
  .sel    (sel_q)
);

// File: tb/tmr_wavegen_tb.sv
module tmr_wavegen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wave_a, wave_b, flag_ovf, flag_cmpa, flag_cmpb, flag_capt;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_wavegen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wave_a(wave_a), .wave_b(wave_b), .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa),
    .flag_cmpb(flag_cmpb), .flag_capt(flag_capt), .count(count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input int mode, input int pa, input int pb, input int sel);
    return 16'((sel << 8) | (pb << 6) | (pa << 4) | mode);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step_gap(output int gap);
    logic [15:0] prev;
    prev = count;
    for (int i = 0; i < 5000; i++) begin @(negedge clk); if (count != prev) break; end
    prev = count; gap = 0;
    for (int i = 0; i < 5000; i++) begin @(negedge clk); gap++; if (count != prev) break; end
  endtask

  task automatic edge_gap(input bit use_b, output int gap);
    logic prev;
    prev = use_b ? wave_b : wave_a;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); if ((use_b ? wave_b : wave_a) != prev) break;
    end
    prev = use_b ? wave_b : wave_a; gap = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); gap++; if ((use_b ? wave_b : wave_a) != prev) break;
    end
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 70000; i++) begin @(negedge clk); if (count == 16'(v)) break; end
  endtask

  task automatic max_until_zero(output int mx);
    mx = 0;
    for (int i = 0; i < 70000; i++) begin @(negedge clk); if (count != 0) break; end
    mx = int'(count);
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
      if (count == 0) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g, mx, hi_a, hi_b, c;
    int plist [5] = '{1, 8, 64, 256, 1024};
    int tlist [5] = '{0, 1, 2, 3, 7};
    int slist [2] = '{1, 2};
    int nlist [2] = '{1, 8};
    int toplist [3] = '{255, 511, 1023};

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(count == 0 && !wave_a && !wave_b, "R1 count/pins", int'(count), 0);
    chk({flag_ovf, flag_cmpa, flag_cmpb, flag_capt} == 4'b0, "R1 flags",
        int'({flag_ovf, flag_cmpa, flag_cmpb, flag_capt}), 0);

    // R2 divider ratios in free-run mode
    for (int s = 1; s <= 5; s++) begin
      wr(3'd0, ctrl(0, 0, 0, s));
      step_gap(g);
      chk(g == plist[s-1], "R2 divide", g, plist[s-1]);
    end
    // R10 pin action 0 keeps pin A low although compare A (0) matches
    chk(!wave_a, "R10 off pin", int'(wave_a), 0);
    foreach (slist[k]) begin end
    for (int s = 0; s < 8; s += 6) begin
      wr(3'd0, ctrl(0, 0, 0, s));
      mx = int'(count);
      repeat (40) @(negedge clk);
      chk(int'(count) == mx, "R2 stopped", int'(count), mx);
    end
    wr(3'd0, ctrl(0, 0, 0, 7));
    mx = int'(count);
    repeat (40) @(negedge clk);
    chk(int'(count) == mx, "R2 stopped code 7", int'(count), mx);

    // R3 clear-on-match toggle period, ceiling from compare A
    foreach (tlist[t]) begin
      foreach (nlist[n]) begin
        do_reset();
        wr(3'd1, 16'(tlist[t]));
        wr(3'd0, ctrl(4, 1, 0, slist[n]));
        edge_gap(1'b0, g);
        chk(g == nlist[n] * (tlist[t] + 1), "R3 toggle period A", g, nlist[n] * (tlist[t] + 1));
      end
    end
    // R8 compare A flag set, ceiling-register flag not set in mode 4
    chk(flag_cmpa && !flag_capt, "R8 flags mode 4", int'({flag_cmpa, flag_capt}), 2);
    // R10 switching pin A off drives it low next clock
    wr(3'd0, ctrl(4, 0, 0, 2));
    chk(!wave_a, "R10 pin off", int'(wave_a), 0);
    repeat (30) @(negedge clk);
    chk(!wave_a, "R10 pin stays off", int'(wave_a), 0);

    // R3 ceiling register in mode 12, pin B toggles on compare B = 0
    for (int t = 0; t < 6; t += 4) begin
      do_reset();
      wr(3'd3, 16'(t));
      wr(3'd0, ctrl(12, 0, 1, 1));
      edge_gap(1'b1, g);
      chk(g == t + 1, "R3 toggle period B mode 12", g, t + 1);
      chk(flag_capt && flag_cmpb && !flag_ovf, "R8 flags mode 12",
          int'({flag_capt, flag_cmpb, flag_ovf}), 6);
    end

    // R4 ceiling lowered below a running count
    do_reset();
    wr(3'd1, 16'd999);
    wr(3'd0, ctrl(4, 0, 0, 1));
    wait_count(500);
    wr(3'd1, 16'd100);
    wr(3'd4, 16'hF);
    mx = 0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
      if (count == 0) break;
    end
    chk(mx == 65535, "R4 full wrap", mx, 65535);
    chk(flag_ovf, "R4 overflow at wrap", int'(flag_ovf), 1);
    chk(!flag_cmpa, "R4 no match before wrap", int'(flag_cmpa), 0);
    c = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); c++; if (count == 0) break; end
    chk(c == 101, "R4 new ceiling period", c, 101);

    // R5 fixed ceilings, R8 overflow at ceiling in PWM
    foreach (toplist[m]) begin
      do_reset();
      wr(3'd0, ctrl(5 + m, 0, 0, 1));
      max_until_zero(mx);
      max_until_zero(mx);
      chk(mx == toplist[m], "R5 fixed ceiling", mx, toplist[m]);
      chk(flag_ovf && flag_cmpa, "R8 PWM overflow/compare", int'({flag_ovf, flag_cmpa}), 3);
    end

    // R9 selective clear with counter stopped
    wr(3'd0, ctrl(7, 0, 0, 0));
    wr(3'd4, 16'h0002);
    chk(!flag_cmpa && flag_ovf, "R9 clear only bit 1", int'({flag_ovf, flag_cmpa}), 2);
    wr(3'd4, 16'h0001);
    chk(!flag_ovf, "R9 clear bit 0", int'(flag_ovf), 0);

    // R5/R6 duty sweep, mode 14 ceiling 9, pin A action 2, pin B action 3
    do_reset();
    wr(3'd3, 16'd9);
    wr(3'd0, ctrl(14, 2, 3, 1));
    for (int m = 0; m <= 9; m++) begin
      wr(3'd1, 16'(m));
      wr(3'd2, 16'(m));
      repeat (25) @(negedge clk);
      hi_a = 0; hi_b = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        hi_a += int'(wave_a); hi_b += int'(wave_b);
      end
      chk(hi_a == m + 1, "R6 non-inverting high time", hi_a, m + 1);
      chk(hi_b == 9 - m, "R6 inverting high time", hi_b, 9 - m);
    end
    max_until_zero(mx);
    chk(mx == 9, "R5 ceiling register in PWM", mx, 9);

    // R7 held compare A as ceiling in mode 15
    do_reset();
    wr(3'd0, ctrl(15, 0, 0, 1));
    wr(3'd1, 16'd19);
    wait_count(5);
    wr(3'd1, 16'd9);
    mx = int'(count);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
      if (count == 0) break;
    end
    chk(mx == 19, "R7 current period kept", mx, 19);
    max_until_zero(mx);
    chk(mx == 9, "R7 next period uses new value", mx, 9);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule